// File: doc/BRIEF.md
# CompactFlash card configuration registers

This block is the attribute-space register file of a CompactFlash or PC Card storage device. The host issues byte reads and writes on the attribute bus. Addresses below a configurable register base fall into the read-only card-information area. The block forwards such an address to an external card-information memory and returns that byte only while the address lies inside the table length. At and above the base there are four byte registers: option, configuration-status, pin-replacement and socket/copy.

The block also builds the card's interrupt line. It combines the raw interrupt level from the drive core, the device-control byte supplied by the task-file block, and any soft reset in progress. Setting the soft-reset bit in the option register clears the card configuration and sends a one-cycle reset request to the rest of the card. Read data is registered and returned one cycle after the request, marked by a valid strobe.

Top module: `cf_cfg_regs`

## Requirements
- R1: While reset is held and after its release, the option register reads 0x00, the status register reads 0x00, the pin register reads 0x0C, and neither irq_o nor attr_rvalid_o is high during reset.
- R2: A read request is answered by attr_rvalid_o high for exactly the next cycle. For an address below REG_BASE, the data is the card-information byte at that address if the address is below CIS_LEN, and 0x00 otherwise.
- R3: Offset 0x0 is the option register. A write with bit 7 clear stores the value ANDed with 0xCF.
- R4: A write to the option register with bit 7 set is a soft reset. It raises srst_o for exactly one cycle and clears the option, status and pin registers.
- R5: Offset 0x2 is the status register. A write loads the written bits under mask 0x74 and keeps bit 7 unchanged. Bit 1 is the interrupt flag and cannot be written.
- R6: When a status write changes the power-down bit (bit 2), the card-ready bit (bit 5) of the pin register is set. It stays set until a reset.
- R7: A status read returns bit 1 as 0 while dev_ctrl_i bit 1 (interrupt disable) is set. Otherwise it returns the stored value.
- R8: Offset 0x4 is the pin register. A read returns the card-ready bit ORed with 0x0C. A write keeps card-ready and takes only bit 1 of the written value, which is never read back.
- R9: Offset 0x6 (socket/copy) and every other offset at or above the base read as 0x00. Writes to them, and writes below the base, change no register.
- R10: irq_o is registered. It is high only when the interrupt flag is clear, dev_ctrl_i bits 1 and 2 are both clear, and no soft reset is in progress. It follows any change of these in the next cycle.
- R11: Status bit 1 follows core_irq_i one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attr_req_i | input | 1 | Attribute access request |
| attr_we_i | input | 1 | 1 = write, 0 = read |
| attr_addr_i | input | ADDR_W | Attribute byte address |
| attr_wdata_i | input | 8 | Write data |
| attr_rdata_o | output | 8 | Read data, registered |
| attr_rvalid_o | output | 1 | Read data valid |
| cis_addr_o | output | ADDR_W | Address to card-information memory |
| cis_data_i | input | 8 | Byte from card-information memory |
| dev_ctrl_i | input | 8 | Device-control byte from task-file block |
| core_irq_i | input | 1 | Raw interrupt level from drive core |
| irq_o | output | 1 | Card interrupt line |
| srst_o | output | 1 | One-cycle soft-reset request |

## Verification
The bench builds the block with an 8-bit attribute address, REG_BASE 0x40 and CIS_LEN 0x30. With these values the in-table area, the gap between the table end and the base, the four registers and the unmapped offsets above them are all reachable in a few cycles. It reads both edges of the table-length boundary. It steps the power-down bit through set, clear and unchanged writes, and it toggles each of the three interrupt gating sources on its own.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    typedef enum logic [2:0] {
        SEL_CIS,
        SEL_OPT,
        SEL_STAT,
        SEL_PIN,
        SEL_SOCK,
        SEL_NONE
    } sel_e;

    localparam logic [7:0] OPT_WMASK  = 8'hCF;
    localparam int         OPT_SRST   = 7;
    localparam logic [7:0] STAT_KEEP  = 8'h82;
    localparam logic [7:0] STAT_LOAD  = 8'h74;
    localparam int         STAT_INT   = 1;
    localparam int         STAT_PWR   = 2;
    localparam int         PIN_RDY    = 5;
    localparam logic [7:0] PIN_WMASK  = 8'h02;
    localparam logic [7:0] PIN_FIXED  = 8'h0C;
    localparam int         CTL_IDIS   = 1;
    localparam int         CTL_SRST   = 2;

    typedef struct packed {
        logic [7:0] opt;
        logic [7:0] stat;
        logic [7:0] pins;
        logic [7:0] rdata;
        logic       rvalid;
        logic       irq;
        logic       srst;
    } state_t;

endpackage

// File: rtl/cfr_decode.sv
module cfr_decode
    import cfr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int REG_BASE = 512,
    parameter int CIS_LEN  = 330
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_e              sel_o,
    output logic              cis_hit_o
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(CIS_LEN);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off       = addr_i - BASE_A;
        cis_hit_o = (addr_i < LEN_A);
        if (addr_i < BASE_A) begin
            sel_o = SEL_CIS;
        end else if (off == ADDR_W'(0)) begin
            sel_o = SEL_OPT;
        end else if (off == ADDR_W'(2)) begin
            sel_o = SEL_STAT;
        end else if (off == ADDR_W'(4)) begin
            sel_o = SEL_PIN;
        end else if (off == ADDR_W'(6)) begin
            sel_o = SEL_SOCK;
        end else begin
            sel_o = SEL_NONE;
        end
    end
endmodule

// File: rtl/cfr_readmux.sv
module cfr_readmux
    import cfr_pkg::*;
(
    input  sel_e       sel_i,
    input  logic       cis_hit_i,
    input  logic [7:0] cis_data_i,
    input  logic [7:0] opt_i,
    input  logic [7:0] stat_i,
    input  logic [7:0] pins_i,
    input  logic       int_mask_i,
    output logic [7:0] rdata_o
);
    logic [7:0] stat_view;

    always_comb begin
        stat_view = stat_i;
        if (int_mask_i) begin
            stat_view[STAT_INT] = 1'b0;
        end
        case (sel_i)
            SEL_CIS:  rdata_o = cis_hit_i ? cis_data_i : 8'h00;
            SEL_OPT:  rdata_o = opt_i;
            SEL_STAT: rdata_o = stat_view;
            SEL_PIN:  rdata_o = (pins_i & (8'h01 << PIN_RDY)) | PIN_FIXED;
            default:  rdata_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfr_irq_gate.sv
module cfr_irq_gate
    import cfr_pkg::*;
(
    input  logic       int_flag_i,
    input  logic [7:0] dev_ctrl_i,
    input  logic       soft_rst_i,
    output logic       irq_o
);
    always_comb begin
        irq_o = !int_flag_i
             && !dev_ctrl_i[CTL_IDIS]
             && !dev_ctrl_i[CTL_SRST]
             && !soft_rst_i;
    end
endmodule

// File: rtl/cf_cfg_regs.sv
module cf_cfg_regs
    import cfr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int REG_BASE = 512,
    parameter int CIS_LEN  = 330
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              attr_req_i,
    input  logic              attr_we_i,
    input  logic [ADDR_W-1:0] attr_addr_i,
    input  logic [7:0]        attr_wdata_i,
    output logic [7:0]        attr_rdata_o,
    output logic              attr_rvalid_o,
    output logic [ADDR_W-1:0] cis_addr_o,
    input  logic [7:0]        cis_data_i,
    input  logic [7:0]        dev_ctrl_i,
    input  logic              core_irq_i,
    output logic              irq_o,
    output logic              srst_o
);
    state_t     s_d, s_q;
    sel_e       sel;
    logic       cis_hit;
    logic [7:0] rd_mux;
    logic       irq_next;
    logic       wr_en, rd_en;

    assign wr_en      = attr_req_i && attr_we_i;
    assign rd_en      = attr_req_i && !attr_we_i;
    assign cis_addr_o = attr_addr_i;

    cfr_decode #(
        .ADDR_W   (ADDR_W),
        .REG_BASE (REG_BASE),
        .CIS_LEN  (CIS_LEN)
    ) u_decode (
        .addr_i    (attr_addr_i),
        .sel_o     (sel),
        .cis_hit_o (cis_hit)
    );

    cfr_readmux u_readmux (
        .sel_i      (sel),
        .cis_hit_i  (cis_hit),
        .cis_data_i (cis_data_i),
        .opt_i      (s_q.opt),
        .stat_i     (s_q.stat),
        .pins_i     (s_q.pins),
        .int_mask_i (dev_ctrl_i[CTL_IDIS]),
        .rdata_o    (rd_mux)
    );

    cfr_irq_gate u_irq (
        .int_flag_i (s_d.stat[STAT_INT]),
        .dev_ctrl_i (dev_ctrl_i),
        .soft_rst_i (s_d.srst),
        .irq_o      (irq_next)
    );

    always_comb begin
        s_d                = s_q;
        s_d.srst           = 1'b0;
        s_d.rvalid         = 1'b0;
        s_d.stat[STAT_INT] = core_irq_i;

        if (wr_en) begin
            case (sel)
                SEL_OPT: begin
                    if (attr_wdata_i[OPT_SRST]) begin
                        s_d.opt  = 8'h00;
                        s_d.stat = 8'h00;
                        s_d.pins = 8'h00;
                        s_d.srst = 1'b1;
                    end else begin
                        s_d.opt = attr_wdata_i & OPT_WMASK;
                    end
                end
                SEL_STAT: begin
                    if (s_q.stat[STAT_PWR] != attr_wdata_i[STAT_PWR]) begin
                        s_d.pins[PIN_RDY] = 1'b1;
                    end
                    s_d.stat = (s_q.stat & STAT_KEEP) | (attr_wdata_i & STAT_LOAD);
                    s_d.stat[STAT_INT] = core_irq_i;
                end
                SEL_PIN: begin
                    s_d.pins = (s_q.pins & (8'h01 << PIN_RDY)) | (attr_wdata_i & PIN_WMASK);
                end
                default: begin
                end
            endcase
        end

        if (rd_en) begin
            s_d.rvalid = 1'b1;
            s_d.rdata  = rd_mux;
        end

        s_d.irq = irq_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign attr_rdata_o  = s_q.rdata;
    assign attr_rvalid_o = s_q.rvalid;
    assign irq_o         = s_q.irq;
    assign srst_o        = s_q.srst;

endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
    parameter int ADDR_W   = 12,
    parameter int REG_BASE = 512,
    parameter int CIS_LEN  = 330
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              attr_req_i,
    input logic              attr_we_i,
    input logic [ADDR_W-1:0] attr_addr_i,
    input logic [7:0]        attr_wdata_i,
    input logic [7:0]        attr_rdata_o,
    input logic              attr_rvalid_o,
    input logic [7:0]        dev_ctrl_i,
    input logic              core_irq_i,
    input logic              irq_o,
    input logic              srst_o
);
    localparam logic [ADDR_W-1:0] OPT_A = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-1:0] PIN_A = ADDR_W'(REG_BASE + 4);

    AST_CTRL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dev_ctrl_i[1] || dev_ctrl_i[2]) |=> !irq_o);                      // R10
    AST_CORE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_irq_i |=> !irq_o);                                            // R10
    AST_SRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_o |-> !irq_o);                                                // R10
    AST_SRST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_o |=> !srst_o);                                               // R4
    AST_SRST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_o |-> $past(attr_req_i && attr_we_i && attr_wdata_i[7]
                         && attr_addr_i == OPT_A));                        // R4
    AST_RD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (attr_req_i && !attr_we_i) |=> attr_rvalid_o);                     // R2
    AST_NO_SPUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(attr_req_i && !attr_we_i) |=> !attr_rvalid_o);                   // R2
    AST_PIN_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (attr_rvalid_o && $past(attr_addr_i) == PIN_A)
            |-> attr_rdata_o[3:2] == 2'b11);                               // R8
endmodule

bind cf_cfg_regs cfr_checker #(
    .ADDR_W   (ADDR_W),
    .REG_BASE (REG_BASE),
    .CIS_LEN  (CIS_LEN)
) u_cfr_checker (.*);

// File: tb/tb_cf_cfg_regs.sv
module tb_cf_cfg_regs;
    localparam int AW   = 8;
    localparam int BASE = 64;
    localparam int LEN  = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic          rvalid;
    logic [AW-1:0] cis_addr;
    logic [7:0]    cis_data;
    logic [7:0]    dev_ctrl = 8'h00;
    logic          core_irq = 1'b0;
    logic          irq;
    logic          srst;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    assign cis_data = cis_addr ^ 8'h5A;

    cf_cfg_regs #(.ADDR_W(AW), .REG_BASE(BASE), .CIS_LEN(LEN)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .attr_req_i(req), .attr_we_i(we), .attr_addr_i(addr),
        .attr_wdata_i(wdata), .attr_rdata_o(rdata), .attr_rvalid_o(rvalid),
        .cis_addr_o(cis_addr), .cis_data_i(cis_data),
        .dev_ctrl_i(dev_ctrl), .core_irq_i(core_irq),
        .irq_o(irq), .srst_o(srst)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R2 unexpected read data: got %h expected none", rdata);
            end else begin
                chk(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic do_wr(input int a, input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic do_rd(input int a, input logic [7:0] e, input string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = AW'(a);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        idle(2);
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R2 missing read data: got %0d pending expected 0", exp_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        chk({7'd0, irq}, 8'h00, "R1 irq in reset");
        chk({7'd0, rvalid}, 8'h00, "R1 rvalid in reset");
        rst_n = 1'b1;
        idle(2);
        do_rd(BASE + 0, 8'h00, "R1 option reset");
        do_rd(BASE + 2, 8'h00, "R1 status reset");
        do_rd(BASE + 4, 8'h0C, "R1 pin reset");
        chk({7'd0, irq}, 8'h01, "R10 irq idle high");

        // card-information area and table-length boundary
        do_rd(8'h00, 8'h5A, "R2 cis 0x00");
        do_rd(8'h10, 8'h4A, "R2 cis 0x10");
        do_rd(8'h2F, 8'h75, "R2 cis last");
        do_rd(8'h30, 8'h00, "R2 past table");
        do_rd(8'h3F, 8'h00, "R2 below base");

        // option masking
        do_wr(BASE + 0, 8'h3F);
        do_rd(BASE + 0, 8'h0F, "R3 option 3F");
        do_wr(BASE + 0, 8'h71);
        do_rd(BASE + 0, 8'h41, "R3 option 71");

        // status write with power-down change
        do_wr(BASE + 2, 8'hFF);
        do_rd(BASE + 2, 8'h74, "R5 status load");
        do_rd(BASE + 4, 8'h2C, "R6 ready set");

        // soft reset
        do_wr(BASE + 0, 8'h80);
        chk({7'd0, srst}, 8'h01, "R4 srst pulse");
        chk({7'd0, irq}, 8'h00, "R10 irq low in soft reset");
        do_rd(BASE + 0, 8'h00, "R4 option cleared");
        chk({7'd0, srst}, 8'h00, "R4 srst one cycle");
        do_rd(BASE + 2, 8'h00, "R4 status cleared");
        do_rd(BASE + 4, 8'h0C, "R4 pin cleared");
        chk({7'd0, irq}, 8'h01, "R10 irq back");

        // pin write does not load card-ready
        do_wr(BASE + 4, 8'hFF);
        do_rd(BASE + 4, 8'h0C, "R8 pin write no ready");

        // power-down unchanged / set / cleared
        do_wr(BASE + 2, 8'h00);
        do_rd(BASE + 4, 8'h0C, "R6 no change no ready");
        do_wr(BASE + 2, 8'h04);
        do_rd(BASE + 2, 8'h04, "R5 pwr bit");
        do_rd(BASE + 4, 8'h2C, "R6 ready on set");
        do_wr(BASE + 2, 8'h00);
        do_rd(BASE + 4, 8'h2C, "R6 ready sticky");
        do_wr(BASE + 4, 8'h00);
        do_rd(BASE + 4, 8'h2C, "R8 pin write keeps ready");

        // raw interrupt, masking of flag
        @(negedge clk); core_irq = 1'b1;
        @(negedge clk);
        chk({7'd0, irq}, 8'h00, "R10 core irq gates");
        do_rd(BASE + 2, 8'h02, "R11 flag follows core");
        @(negedge clk); dev_ctrl = 8'h02;
        do_rd(BASE + 2, 8'h00, "R7 flag masked");
        @(negedge clk); dev_ctrl = 8'h00;
        do_wr(BASE + 2, 8'h00);
        do_rd(BASE + 2, 8'h02, "R5 flag not writable");
        @(negedge clk); core_irq = 1'b0;
        @(negedge clk);
        chk({7'd0, irq}, 8'h01, "R10 core released");
        do_rd(BASE + 2, 8'h00, "R11 flag cleared");

        // device-control gating
        @(negedge clk); dev_ctrl = 8'h02;
        @(negedge clk);
        chk({7'd0, irq}, 8'h00, "R10 idis gates");
        dev_ctrl = 8'h04;
        @(negedge clk);
        chk({7'd0, irq}, 8'h00, "R10 srst ctrl gates");
        dev_ctrl = 8'h00;
        @(negedge clk);
        chk({7'd0, irq}, 8'h01, "R10 ctrl released");

        // unmapped offsets and ignored writes
        do_wr(BASE + 0, 8'h41);
        do_wr(BASE + 6, 8'hFF);
        do_wr(BASE + 8, 8'hFF);
        do_wr(BASE + 1, 8'hFF);
        do_wr(8'h10, 8'hFF);
        do_rd(BASE + 6, 8'h00, "R9 socket reads 0");
        do_rd(BASE + 8, 8'h00, "R9 unmapped reads 0");
        do_rd(BASE + 1, 8'h00, "R9 odd offset reads 0");
        do_rd(BASE + 0, 8'h41, "R9 option untouched");
        do_rd(BASE + 2, 8'h00, "R9 status untouched");
        do_rd(BASE + 4, 8'h2C, "R9 pin untouched");
        do_rd(8'h10, 8'h4A, "R9 cis untouched");
        chk({7'd0, irq}, 8'h01, "R10 irq after ignored writes");

        finish_run();
    end
endmodule